// File: doc/BRIEF.md
# Indexed Mixer Register Port

This block is a byte-wide register file of 256 locations that a host reaches through two ports sharing one data path. The host selects the index port or the data port with `hostSel`. A write to the index port chooses the location. Accesses to the data port then read or write that location.

Two locations behave differently from plain storage:
- Location 0x40 answers data-port reads with a four-byte identification signature. The signature is returned one byte per read and wraps around after the last byte.
- Location 0x00 treats a data-port write as a command to clear the whole file.

The block also decodes a few stored bytes live into control outputs:
- Location 0x40 drives the resource outputs for a MIDI port, a game port and an FM synth window.
- Location 0x0E drives a stereo-mode flag.

The host uses the block as the control plane of an audio mixer. It places the attached peripherals by writing location 0x40, and it identifies the device by reading the signature. Reads have combinational data: `hostRdata` is valid in the same cycle as `hostRe`. Any side effect of an access takes place at the clock edge that ends it.

Top module: `mixRegPort`

## Requirements
- R1: After the synchronous reset `rst`, the following hold:
  - The index, the signature step and all 256 registers are zero.
  - `midiEn`, `midiIrqSel`, `gameEn`, `gameBase`, `fmEn` and `stereoEn` are 0.
  - `midiBase` is 0x300.
- R2: With `hostSel`=0, a write stores `hostWdata` as the current index and also stores it into register 0x01. A read with `hostSel`=0 returns the current index.
- R3: With `hostSel`=1, a write stores `hostWdata` into the selected register. A read returns the stored byte for every index except 0x40. Reads at any index other than 0x40 have no side effect.
- R4: A data-port read at index 0x40 returns signature byte number p, then advances p by one. After byte 3, p returns to byte 0. With the default parameter the bytes are 0x5A, 0xA5, 0x3C, 0xC3, in that order.
- R5: Writing 0x40 to the index port sets the signature step p back to byte 0, whatever its value was.
- R6: A data-port write while the index is 0x00 clears all 256 registers to zero in that clock edge. The written value is not stored, and the index stays 0x00.
- R7: Registers 0x02 and 0x22 are linked, and so are registers 0x06 and 0x26. A data-port write to either member of a pair stores the same byte into both members. No other register changes with it.
- R8: `midiBase` equals 0x300 OR (register 0x40 bits 4:3 placed at address bits 5:4). It can therefore take the values 0x300, 0x310, 0x320 or 0x330.
- R9: `midiIrqSel` is register 0x40 bits 7:5. `midiEn` is 1 exactly when that field is nonzero.
- R10: `gameEn` equals register 0x40 bit 1. `gameBase` is 0x200 when that bit is set and 0x000 when it is clear.
- R11: `fmEn` equals register 0x40 bit 0.
- R12: `stereoEn` equals register 0x0E bit 1.
- R13: When `hostWe` and `hostRe` are asserted together, only the write takes effect: the read does not advance the signature step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hostSel | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| hostWe | input | 1 | Write strobe for this cycle |
| hostRe | input | 1 | Read strobe for this cycle |
| hostWdata | input | 8 | Write byte |
| hostRdata | output | 8 | Read byte, combinational |
| stereoEn | output | 1 | Stereo mode flag |
| midiEn | output | 1 | MIDI port and its interrupt enabled |
| midiIrqSel | output | 3 | MIDI interrupt selector |
| midiBase | output | ADDR_W | MIDI port base address |
| gameEn | output | 1 | Game port mapped |
| gameBase | output | ADDR_W | Game port base address, or 0 when unmapped |
| fmEn | output | 1 | FM synth window enabled |

## Verification
The assertions check three things on every cycle:
- how the signature step behaves: it advances and wraps on each signature read, restarts when index 0x40 is selected, and holds on every other cycle, including a cycle with a simultaneous write and read;
- that a clear command empties the file;
- that a write to one member of a linked pair lands in the other member.

Only the bench scenarios show the values a host actually sees:
- the signature byte order;
- the mirror of the index into register 0x01;
- the effect of the clear command, observed at the ports;
- the decoded base addresses and enables for several configuration bytes.

// File: rtl/mixRegPkg.sv
package mixRegPkg;
  localparam int IDX_W     = 8;
  localparam int DATA_W    = 8;
  localparam int REG_COUNT = 1 << IDX_W;

  localparam logic [IDX_W-1:0] CMD_IDX    = 8'h00;
  localparam logic [IDX_W-1:0] MIRROR_IDX = 8'h01;
  localparam logic [IDX_W-1:0] MODE_IDX   = 8'h0E;
  localparam logic [IDX_W-1:0] SIG_IDX    = 8'h40;
  localparam logic [IDX_W-1:0] LINK_BIT   = 8'h20;

  typedef struct packed {
    logic idxWr;   // index port write
    logic dataWr;  // data port write that stores a byte
    logic clrAll;  // data port write at the command index
    logic sigRd;   // data port read at the signature index
  } mixStrobe_t;

  function automatic logic isLinked(input logic [IDX_W-1:0] idx);
    return (idx == 8'h02) || (idx == 8'h22) || (idx == 8'h06) || (idx == 8'h26);
  endfunction
endpackage

// File: rtl/mixCtrl.sv
module mixCtrl
  import mixRegPkg::*;
#(
  parameter int SIG_LEN = 4,
  localparam int PTR_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [DATA_W-1:0] hostWdata,
  output mixStrobe_t        strb,
  output logic [IDX_W-1:0]  curIdx,
  output logic [PTR_W-1:0]  sigPtr
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SIG_LEN - 1);

  always_comb begin
    strb.idxWr  = hostWe && !hostSel;
    strb.dataWr = hostWe && hostSel && (curIdx != CMD_IDX);
    strb.clrAll = hostWe && hostSel && (curIdx == CMD_IDX);
    strb.sigRd  = hostRe && !hostWe && hostSel && (curIdx == SIG_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curIdx <= '0;
    end else if (strb.idxWr) begin
      curIdx <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sigPtr <= '0;
    end else if (strb.idxWr && hostWdata == SIG_IDX) begin
      sigPtr <= '0;
    end else if (strb.sigRd) begin
      sigPtr <= (sigPtr == PTR_LAST) ? '0 : sigPtr + 1'b1;
    end
  end

  // R4
  sig_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.sigRd |=> sigPtr == (($past(sigPtr) == PTR_LAST) ? '0 : $past(sigPtr) + 1'b1));

  // R5
  sig_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (hostWe && !hostSel && hostWdata == SIG_IDX) |=> sigPtr == '0);

  // R13
  sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(hostRe && !hostWe && hostSel && curIdx == SIG_IDX) &&
     !(hostWe && !hostSel && hostWdata == SIG_IDX)) |=> $stable(sigPtr));
endmodule

// File: rtl/mixData.sv
module mixData
  import mixRegPkg::*;
#(
  parameter int SIG_LEN = 4,
  parameter logic [8*SIG_LEN-1:0] SIG_BYTES = 32'hC33CA55A,
  localparam int PTR_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  mixStrobe_t        strb,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [PTR_W-1:0]  sigPtr,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [6:0]        cfgFields,
  output logic              modeStereo
);
  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [DATA_W-1:0] sigByte;
  logic [DATA_W-1:0] cfgByte;

  always_ff @(posedge clk) begin
    if (rst || strb.clrAll) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (strb.idxWr) begin
      regFile[MIRROR_IDX] <= hostWdata;
    end else if (strb.dataWr) begin
      regFile[curIdx] <= hostWdata;
      if (isLinked(curIdx)) regFile[curIdx ^ LINK_BIT] <= hostWdata;
    end
  end

  always_comb begin
    sigByte = SIG_BYTES[7:0];
    for (int k = 0; k < SIG_LEN; k++) begin
      if (sigPtr == PTR_W'(k)) sigByte = SIG_BYTES[8*k +: 8];
    end
  end

  always_comb begin
    if (!hostSel)                hostRdata = curIdx;
    else if (curIdx == SIG_IDX)  hostRdata = sigByte;
    else                         hostRdata = regFile[curIdx];
  end

  assign cfgByte    = regFile[SIG_IDX];
  assign cfgFields  = {cfgByte[7:3], cfgByte[1:0]};
  assign modeStereo = regFile[MODE_IDX][1];

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clrAll |=> (regFile[SIG_IDX] == '0 && regFile[MODE_IDX] == '0 &&
                     regFile[MIRROR_IDX] == '0 && curIdx == CMD_IDX));

  // R7
  link_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.dataWr && curIdx == 8'h02) |=> regFile[8'h22] == $past(hostWdata));
endmodule

// File: rtl/mixCfgDecode.sv
module mixCfgDecode #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] MIDI_BASE = 10'h300,
  parameter logic [ADDR_W-1:0] GAME_BASE = 10'h200
) (
  input  logic [6:0]        cfgFields,  // {irq[2:0], midiSlot[1:0], game, fm}
  input  logic              modeStereo,
  output logic              stereoEn,
  output logic              midiEn,
  output logic [2:0]        midiIrqSel,
  output logic [ADDR_W-1:0] midiBase,
  output logic              gameEn,
  output logic [ADDR_W-1:0] gameBase,
  output logic              fmEn
);
  assign midiIrqSel = cfgFields[6:4];
  assign midiEn     = |cfgFields[6:4];
  assign midiBase   = MIDI_BASE | ADDR_W'({cfgFields[3:2], 4'b0000});
  assign gameEn     = cfgFields[1];
  assign gameBase   = cfgFields[1] ? GAME_BASE : '0;
  assign fmEn       = cfgFields[0];
  assign stereoEn   = modeStereo;
endmodule

// File: rtl/mixRegPort.sv
module mixRegPort
  import mixRegPkg::*;
#(
  parameter int SIG_LEN = 4,
  parameter logic [8*SIG_LEN-1:0] SIG_BYTES = 32'hC33CA55A,
  parameter int ADDR_W = 10,
  localparam int PTR_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              stereoEn,
  output logic              midiEn,
  output logic [2:0]        midiIrqSel,
  output logic [ADDR_W-1:0] midiBase,
  output logic              gameEn,
  output logic [ADDR_W-1:0] gameBase,
  output logic              fmEn
);
  mixStrobe_t       strb;
  logic [IDX_W-1:0] curIdx;
  logic [PTR_W-1:0] sigPtr;
  logic [6:0]       cfgFields;
  logic             modeStereo;

  mixCtrl #(.SIG_LEN(SIG_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWe(hostWe), .hostRe(hostRe),
    .hostWdata(hostWdata), .strb(strb), .curIdx(curIdx), .sigPtr(sigPtr)
  );

  mixData #(.SIG_LEN(SIG_LEN), .SIG_BYTES(SIG_BYTES)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .curIdx(curIdx), .sigPtr(sigPtr),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .cfgFields(cfgFields), .modeStereo(modeStereo)
  );

  mixCfgDecode #(
    .ADDR_W(ADDR_W),
    .MIDI_BASE(ADDR_W'(10'h300)),
    .GAME_BASE(ADDR_W'(10'h200))
  ) u_dec (
    .cfgFields(cfgFields), .modeStereo(modeStereo), .stereoEn(stereoEn),
    .midiEn(midiEn), .midiIrqSel(midiIrqSel), .midiBase(midiBase),
    .gameEn(gameEn), .gameBase(gameBase), .fmEn(fmEn)
  );
endmodule

// File: tb/mixRegPort_bench.sv
module mixRegPort_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       hostSel, hostWe, hostRe;
  logic [7:0] hostWdata;
  logic [7:0] hostRdata;
  logic       stereoEn, midiEn, gameEn, fmEn;
  logic [2:0] midiIrqSel;
  logic [9:0] midiBase, gameBase;

  int    nRun  = 0;
  int    nFail = 0;
  bit    done  = 1'b0;
  byte   expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mixRegPort u_mixRegPort (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWe(hostWe), .hostRe(hostRe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .stereoEn(stereoEn),
    .midiEn(midiEn), .midiIrqSel(midiIrqSel), .midiBase(midiBase),
    .gameEn(gameEn), .gameBase(gameBase), .fmEn(fmEn)
  );

  // monitor: pops one expected byte per read-only cycle
  always @(negedge clk) begin
    if (!rst && hostRe && !hostWe) begin
      nRun++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", hostRdata);
      end else begin
        automatic byte   e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (hostRdata !== e) begin
          nFail++;
          $display("FAIL %s: actual %02h expected %02h", t, hostRdata, e);
        end
      end
    end
  end

  task automatic access(input bit sel, input bit we, input bit re, input logic [7:0] d);
    @(posedge clk); #1;
    hostSel = sel; hostWe = we; hostRe = re; hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0; hostRe = 1'b0;
  endtask

  task automatic selIdx(input logic [7:0] i);
    access(1'b0, 1'b1, 1'b0, i);
  endtask

  task automatic wrData(input logic [7:0] d);
    access(1'b1, 1'b1, 1'b0, d);
  endtask

  task automatic rdPort(input bit sel, input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    access(sel, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkCfg(input string tag, input int irq, input int mb, input int ge,
                        input int fe);
    chk({tag, " midiIrqSel"}, midiIrqSel, irq);
    chk({tag, " midiEn"}, midiEn, irq != 0);
    chk({tag, " midiBase"}, midiBase, mb);
    chk({tag, " gameEn"}, gameEn, ge);
    chk({tag, " gameBase"}, gameBase, ge ? 'h200 : 0);
    chk({tag, " fmEn"}, fmEn, fe);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hostSel = 1'b0; hostWe = 1'b0; hostRe = 1'b0; hostWdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chkCfg("R1", 0, 'h300, 0, 0);
    chk("R1 stereoEn", stereoEn, 0);
    rdPort(1'b0, 8'h00, "R1 index");
    rdPort(1'b1, 8'h00, "R1 reg0");

    // R3 store and read back, reads without side effect
    selIdx(8'h10);
    wrData(8'h77);
    rdPort(1'b1, 8'h77, "R3 first read");
    rdPort(1'b1, 8'h77, "R3 repeat read");
    rdPort(1'b0, 8'h10, "R2 index readback");

    // R2 mirror into register 0x01
    selIdx(8'h01);
    wrData(8'h99);
    rdPort(1'b1, 8'h99, "R3 reg01 stored");
    selIdx(8'h01);
    rdPort(1'b1, 8'h01, "R2 mirror");

    // R7 linked pairs
    selIdx(8'h02); wrData(8'hAB);
    selIdx(8'h22); rdPort(1'b1, 8'hAB, "R7 02->22");
    wrData(8'hCD);
    selIdx(8'h02); rdPort(1'b1, 8'hCD, "R7 22->02");
    selIdx(8'h26); wrData(8'h12);
    selIdx(8'h06); rdPort(1'b1, 8'h12, "R7 26->06");
    selIdx(8'h23); rdPort(1'b1, 8'h00, "R7 unlinked 23");

    // R12 stereo flag
    selIdx(8'h0E); wrData(8'h02);
    chk("R12 set", stereoEn, 1);
    wrData(8'h01);
    chk("R12 clear", stereoEn, 0);

    // R8 R9 R10 R11 configuration decode
    selIdx(8'h40); wrData(8'hB3);
    chkCfg("R8 R9 R10 R11 cfgB3", 5, 'h320, 1, 1);
    wrData(8'h18);
    chkCfg("R8 R9 R10 R11 cfg18", 0, 'h330, 0, 0);
    wrData(8'h2A);
    chkCfg("R8 R9 R10 R11 cfg2A", 1, 'h310, 1, 0);

    // R4 signature cycling
    rdPort(1'b1, 8'h5A, "R4 byte0");
    rdPort(1'b1, 8'hA5, "R4 byte1");
    rdPort(1'b1, 8'h3C, "R4 byte2");
    rdPort(1'b1, 8'hC3, "R4 byte3");
    rdPort(1'b1, 8'h5A, "R4 wrap");

    // R5 reselect restarts the sequence
    selIdx(8'h40);
    rdPort(1'b1, 8'h5A, "R5 restart");
    rdPort(1'b1, 8'hA5, "R5 next");
    selIdx(8'h41);
    selIdx(8'h40);
    rdPort(1'b1, 8'h5A, "R5 after other index");

    // R13 write wins over a simultaneous read
    access(1'b1, 1'b1, 1'b1, 8'h21);
    chkCfg("R13 write applied", 1, 'h300, 0, 1);
    rdPort(1'b1, 8'hA5, "R13 step held");

    // R6 clear command
    selIdx(8'h00);
    wrData(8'h5E);
    rdPort(1'b1, 8'h00, "R6 value not stored");
    rdPort(1'b0, 8'h00, "R6 index kept");
    chkCfg("R6", 0, 'h300, 0, 0);
    chk("R6 stereoEn", stereoEn, 0);
    selIdx(8'h10); rdPort(1'b1, 8'h00, "R6 reg10 cleared");
    selIdx(8'h02); rdPort(1'b1, 8'h00, "R6 reg02 cleared");

    repeat (2) @(posedge clk);
    chk("scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule